// File: doc/BRIEF.md
# Fractional-Rate Clock-Enable Generator

This block turns a system clock into a clock-enable pulse train whose average rate is an arbitrary fraction of the clock rate. A phase register accumulates a step value on every clock. It wraps at a programmable modulus, and the modulus does not have to be a power of two. When the running sum reaches or passes the modulus, the modulus is subtracted and the remainder is kept. The same edge raises the enable output for one clock. Because the remainder carries across every wrap, over any window of `mod_i` clocks the block emits exactly `inc_i` pulses. The average enable rate is therefore f_clk * inc_i / mod_i. For example, a step of 12288 with a modulus of 100000 on a 10 MHz clock gives 1.2288 MHz.

Downstream logic samples `ce_o` to run at the derived rate. `phase_o` exposes the current position within the modulus cycle. A configuration is usable only when 1 <= `inc_i` <= `mod_i` - 1. Any other configuration is flagged at once on `cfg_err_o`, and while it is applied the phase is frozen and the enable stays low. New step or modulus values act on the next clock edge.

Top module: `frac_ce_gen`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it is released with an invalid configuration applied, `phase_o` is 0 and `ce_o` is 0.
- R2: With a valid configuration, if `phase_o + inc_i < mod_i` at an edge, then after that edge `phase_o` equals the old phase plus `inc_i` and `ce_o` is 0.
- R3: With a valid configuration, if `phase_o < mod_i` and `phase_o + inc_i >= mod_i` at an edge, then after that edge `phase_o` equals `phase_o + inc_i - mod_i` and `ce_o` is 1 for that clock. Wraps on back-to-back edges give back-to-back high cycles.
- R4: The modulus is arbitrary. With modulus 15 and step 7 from phase 0, the phase visits 7, 14, 6, and `ce_o` is high only on the step to 6.
- R5: With a fixed valid configuration, any run of `mod_i` consecutive edges produces exactly `inc_i` high cycles on `ce_o`, whatever the starting phase.
- R6: `cfg_err_o` is 1 in the same cycle that `inc_i == 0` or `inc_i >= mod_i`, and 0 otherwise. At an edge taken while `cfg_err_o` is 1, `phase_o` holds and `ce_o` becomes 0.
- R7: Changes to `inc_i` or `mod_i` act on the first edge after they are applied, with no extra latency.
- R8: With a valid configuration, if `phase_o >= mod_i` (the modulus was lowered below the phase), the next edge clears `phase_o` to 0 with `ce_o` 0.
- R9: With the default 17-bit width, a step of 12288 and a modulus of 100000 give exactly 12288 enable pulses in 100000 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | W (17) | Phase step added each clock |
| mod_i | input | W (17) | Wrap modulus |
| ce_o | output | 1 | Registered one-clock enable pulse for each wrap |
| phase_o | output | W (17) | Current phase, 0 to mod_i-1 in normal operation |
| cfg_err_o | output | 1 | Step or modulus out of range (combinational) |

## Verification
The bench builds the block with the default width of W=17. At that width a modulus of 100000 fits, so the full R9 pulse count over one complete 100000-clock window can be checked. A small non-binary modulus of 15 is used to follow the wrap sequence and the remainder cycle by cycle. Modulus 5 brings in consecutive wraps and the case where the modulus is lowered below the phase.

// File: rtl/frac_ce_pkg.sv
package frac_ce_pkg;
  // Per-edge action chosen by the step logic
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_WRAP  = 2'd2,
    ACT_CLEAR = 2'd3
  } frac_act_e;
endpackage

// File: rtl/frac_ce_cfg_chk.sv
module frac_ce_cfg_chk #(
  parameter int unsigned W = 17
) (
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] mod_i,
  output logic         err_o
);
  logic inc_zero;
  logic inc_ge_mod;

  assign inc_zero   = (inc_i == '0);
  assign inc_ge_mod = (inc_i >= mod_i);
  assign err_o      = inc_zero | inc_ge_mod;

  // R6: a zero step is always invalid, whatever the modulus
  always_comb begin
    if (inc_i == '0) a_r6_zero_step_err: assert (err_o);
  end
endmodule

// File: rtl/frac_ce_step.sv
module frac_ce_step
  import frac_ce_pkg::*;
#(
  parameter int unsigned W = 17
) (
  input  logic [W-1:0] phase_i,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] mod_i,
  input  logic         err_i,
  output frac_act_e    act_o,
  output logic [W-1:0] nxt_o
);
  logic [W:0]   sum;
  logic [W-1:0] rem;
  logic         out_of_range;
  logic         wrap;

  assign sum          = {1'b0, phase_i} + {1'b0, inc_i};
  // sum < 2*mod here, so the low W bits of the difference are exact
  assign rem          = sum[W-1:0] - mod_i;
  assign out_of_range = (phase_i >= mod_i);
  assign wrap         = (sum >= {1'b0, mod_i});

  always_comb begin
    act_o = ACT_HOLD;
    nxt_o = phase_i;
    if (!err_i) begin
      if (out_of_range) begin
        act_o = ACT_CLEAR;
        nxt_o = '0;
      end else if (wrap) begin
        act_o = ACT_WRAP;
        nxt_o = rem;
      end else begin
        act_o = ACT_STEP;
        nxt_o = sum[W-1:0];
      end
    end
  end
endmodule

// File: rtl/frac_ce_gen.sv
module frac_ce_gen
  import frac_ce_pkg::*;
#(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] mod_i,
  output logic         ce_o,
  output logic [W-1:0] phase_o,
  output logic         cfg_err_o
);
  logic [W-1:0] phase_q;
  logic [W-1:0] phase_d;
  logic         ce_q;
  logic         err;
  frac_act_e    act;

  frac_ce_cfg_chk #(.W(W)) u_cfg (
    .inc_i (inc_i),
    .mod_i (mod_i),
    .err_o (err)
  );

  frac_ce_step #(.W(W)) u_step (
    .phase_i (phase_q),
    .inc_i   (inc_i),
    .mod_i   (mod_i),
    .err_i   (err),
    .act_o   (act),
    .nxt_o   (phase_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      ce_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ce_q    <= (act == ACT_WRAP);
    end
  end

  assign ce_o      = ce_q;
  assign phase_o   = phase_q;
  assign cfg_err_o = err;

  // R6: an invalid configuration freezes the phase and blocks the pulse
  a_r6_invalid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> (!ce_o && $stable(phase_o)));

  // R3: a pulse always leaves the phase inside the modulus that produced it
  a_r3_wrap_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> (phase_o < $past(mod_i)));

  // R2: a valid step that does not reach the modulus adds the step, no pulse
  a_r2_plain_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_err_o && ({1'b0, phase_o} + {1'b0, inc_i} < {1'b0, mod_i}))
    |=> (!ce_o && (phase_o == $past(phase_o) + $past(inc_i))));

  // R8: a phase stranded above a lowered modulus is cleared
  a_r8_clear_stranded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_err_o && (phase_o >= mod_i)) |=> (!ce_o && (phase_o == '0)));
endmodule

// File: tb/tb_frac_ce_gen.sv
`timescale 1ns/1ps
module tb_frac_ce_gen;
  localparam int W = 17;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] inc_i = '0;
  logic [W-1:0] mod_i = 17'd15;
  logic         ce_o;
  logic [W-1:0] phase_o;
  logic         cfg_err_o;

  int checks = 0;
  int failures = 0;
  int ce_count = 0;
  bit done = 1'b0;

  logic [W:0] exp_q[$];
  string      tag_q[$];
  longint     m_ph = 0;

  always #10 clk_i = ~clk_i;

  frac_ce_gen #(.W(W)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc_i),
    .mod_i     (mod_i),
    .ce_o      (ce_o),
    .phase_o   (phase_o),
    .cfg_err_o (cfg_err_o)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: apply config at negedge, model the next edge, queue the expectation
  task automatic step(input longint inc, input longint md, input string tag);
    bit v;
    bit ce;
    longint s;
    @(negedge clk_i);
    inc_i = inc[W-1:0];
    mod_i = md[W-1:0];
    v = (inc != 0) && (inc < md);
    #1 check({tag, " R6 err"}, cfg_err_o, !v);
    ce = 1'b0;
    if (v) begin
      if (m_ph >= md) m_ph = 0;
      else begin
        s = m_ph + inc;
        if (s >= md) begin
          m_ph = s - md;
          ce = 1'b1;
        end else m_ph = s;
      end
    end
    exp_q.push_back({ce, m_ph[W-1:0]});
    tag_q.push_back(tag);
  endtask

  // monitor: compare each result shortly after the edge that produced it
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (ce_o) ce_count++;
      if (exp_q.size() != 0) begin
        logic [W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " ce"}, ce_o, e[W]);
        check({t, " phase"}, phase_o, e[W-1:0]);
      end
    end
  end

  initial begin
    #(20.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0;
    inc_i = '0;
    mod_i = 17'd15;
    repeat (3) @(posedge clk_i);
    #5;
    check("R1 reset phase", phase_o, 0);
    check("R1 reset ce", ce_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // invalid config right after reset: state stays at reset values
    step(0, 15, "R1 R6 zero step");
    step(0, 15, "R6 zero step hold");
    // R4: 7, 14, 6 with modulus 15
    step(7, 15, "R4 R2 first");
    step(7, 15, "R4 R2 second");
    step(7, 15, "R4 R3 wrap remainder");
    // R5: 15 edges give exactly 7 pulses
    @(posedge clk_i); #6;
    c0 = ce_count;
    for (int i = 0; i < 15; i++) step(7, 15, "R5 window");
    @(posedge clk_i); #6;
    check("R5 pulses in window", ce_count - c0, 7);
    // R6: step equal to modulus is invalid, phase holds
    step(15, 15, "R6 step eq mod");
    step(20, 15, "R6 step gt mod");
    step(15, 15, "R6 hold");
    // R8: phase 6 stranded above modulus 5
    step(1, 5, "R8 clear");
    // R7 and R3: new config acts at once, consecutive wraps
    step(4, 5, "R7 R2 new step");
    step(4, 5, "R3 wrap a");
    step(4, 5, "R3 wrap b");
    step(2, 9, "R7 new modulus");
    step(8, 9, "R3 wrap to 0 region");
    // R9: full-width window
    step(12288, 100000, "R9 prime");
    @(posedge clk_i); #6;
    c0 = ce_count;
    for (int i = 0; i < 100000; i++) step(12288, 100000, "R9 window");
    @(posedge clk_i); #6;
    check("R9 pulses in 100000 clocks", ce_count - c0, 12288);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule